// File: doc/BRIEF.md
# Nonvolatile Store/Recall Command Controller

This block controls a static RAM that is backed by a nonvolatile copy. It samples an asynchronous-style memory bus (a 16-bit compare address, active-low chip enable, output enable and write enable) in the system clock domain. It recognises a software unlock made of six reads from fixed addresses, and it also accepts a store request on a shared open-drain busy line and a power-fail condition reported on a power-good input. From these it starts store, recall and restore operations toward the nonvolatile array. Each operation is modelled as a timed clear or copy strobe.

While an operation runs the controller takes the RAM off the bus. It pulls the shared busy line low for the whole of every store. After a store it holds the RAM disabled until that line reads high again. A dirty flag records RAM writes. Stores started by the busy line or by power failure depend on that flag; a software store always runs. An auto-store inhibit setting can suppress the power-fail store. The setting keeps its value across power loss.

All interfaces here are plain control and status pins. No data stream crosses the block, so it has no valid/ready handshake.

Top module: `nv_cmd_ctrl`

## Requirements
- R1: An access starts on a cycle where `ce_n` is low after a cycle where it was high. A command is issued only after six read starts (`we_n` high) in order. The first five addresses are 16'h4E38, 16'h B1C7, 16'h83E0, 16'h7C1F and 16'h703F. The sixth address selects the command: 16'h8FC0 is store, 16'h4C63 is recall, 16'h8B45 sets the auto-store inhibit, and 16'h4B46 clears it. Cycles with `ce_n` high do not break the sequence.
- R2: A cycle with `ce_n` and `we_n` both low aborts the sequence. So does a read whose address is not the expected one. After an abort, no command results from the remaining reads.
- R3: A software store runs whether or not the RAM is dirty. `arr_store` and `busy_pull` are high for exactly STORE_CYC cycles (default 40).
- R4: In idle with power good, a low `busy_line_n` that the block is not pulling opens a window of HW_DELAY_CYC cycles (default 10). During that window `ram_en` stays high. At the end a store runs only if a RAM write has happened since the last store or recall. Otherwise no store runs.
- R5: While `busy_line_n` is low, `ram_wr_en` rises only for a write that was already accepted in the previous cycle. A write started after the request is blocked.
- R6: After a store, or after a skipped hardware store, `ram_en` stays low until `busy_line_n` reads high.
- R7: A recall drives `arr_clear` for one cycle, then `arr_load` for RECALL_CYC cycles (default 20). The store strobe stays low throughout, and the dirty flag is cleared.
- R8: The inhibit commands set `auto_inhibit` to 1 or 0. Its value after reset is INHIBIT_INIT (default 0), and a power loss and return leave it unchanged. While it is 1, a power failure starts no store.
- R9: When power_good falls in idle, a store runs if the RAM is dirty and inhibit is 0. Otherwise the block goes straight to power-down. While power is down, `ram_wr_en` and `ram_en` stay low and busy-line requests are ignored.
- R10: Power returning, and reset with power good, start a restore: `arr_clear` for one cycle, then `arr_load` for RESTORE_CYC cycles (default 30). After that `ram_en` goes high.
- R11: While any operation runs, `ram_en` and `dq_oe` stay low, and unlock reads are ignored. The sequence detector restarts from empty once the block is idle again. In idle, `dq_oe` is high for a read with `ce_n` and `oe_n` low and `we_n` high.
- R12: In idle, the events are served in this order: power failure first, then a busy-line request, then a software command. A command whose sixth read falls in the same cycle as a busy-line request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 16 | Lower address bits used for unlock compare |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| power_good | input | 1 | High while supply is above the switch level |
| busy_line_n | input | 1 | Sensed level of the shared open-drain busy line |
| busy_pull | output | 1 | 1 pulls the shared busy line low |
| ram_en | output | 1 | RAM may be accessed |
| ram_wr_en | output | 1 | Current write cycle is accepted by the RAM |
| dq_oe | output | 1 | Data bus output drive enable |
| arr_store | output | 1 | Copy RAM to nonvolatile array (level) |
| arr_clear | output | 1 | Clear RAM contents (one cycle) |
| arr_load | output | 1 | Copy nonvolatile array into RAM (level) |
| auto_inhibit | output | 1 | Auto-store inhibit setting |

## Verification
The sixth unlock read and an external pull on the busy line can arrive in the same cycle. The bench provokes this by raising its own pull on the same clock as the final store-code read while the RAM is clean. It judges the result by counting strobes: no store or clear strobe may appear. `ram_en` must stay low until the pull is released, and a later full recall sequence must still work. A second overlap, a write already in flight when the busy line falls, is driven cycle by cycle. The bench checks that `ram_wr_en` holds for that write and stays low for the next one.

// File: rtl/nv_cmd_pkg.sv
package nv_cmd_pkg;
  localparam int unsigned CMP_W   = 16;
  localparam int unsigned SEQ_LEN = 6;
  localparam int unsigned NUM_CMD = 4;
  localparam int unsigned IDX_W   = $clog2(SEQ_LEN);

  typedef enum logic [1:0] {
    CMD_STORE   = 2'd0,
    CMD_RECALL  = 2'd1,
    CMD_INH_ON  = 2'd2,
    CMD_INH_OFF = 2'd3
  } nv_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HWDLY  = 3'd1,
    ST_STORE  = 3'd2,
    ST_WAITHI = 3'd3,
    ST_PWROFF = 3'd4,
    ST_CLEAR  = 3'd5,
    ST_LOAD   = 3'd6
  } nv_st_e;

  function automatic logic [CMP_W-1:0] prefix_addr(input logic [IDX_W-1:0] i);
    case (i)
      3'd0:    return 16'h4E38;
      3'd1:    return 16'hB1C7;
      3'd2:    return 16'h83E0;
      3'd3:    return 16'h7C1F;
      default: return 16'h703F;
    endcase
  endfunction

  function automatic logic [CMP_W-1:0] code_addr(input logic [1:0] c);
    case (c)
      2'd0:    return 16'h8FC0;
      2'd1:    return 16'h4C63;
      2'd2:    return 16'h8B45;
      default: return 16'h4B46;
    endcase
  endfunction
endpackage

// File: rtl/nv_seq_detect.sv
module nv_seq_detect
  import nv_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CMP_W-1:0] addr,
  input  logic             ce_n,
  input  logic             we_n,
  output logic             cmd_vld,
  output nv_cmd_e          cmd
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SEQ_LEN - 1);

  logic             ce_q;
  logic [IDX_W-1:0] idx_q;
  logic             rd_start, wr_seen, pre_hit, first_hit, code_hit;
  nv_cmd_e          code_sel;

  always_comb begin
    rd_start  = en && !ce_n && we_n && ce_q;
    wr_seen   = en && !ce_n && !we_n;
    pre_hit   = (addr == prefix_addr(idx_q));
    first_hit = (addr == prefix_addr('0));
    code_hit  = 1'b0;
    code_sel  = CMD_STORE;
    for (int k = 0; k < NUM_CMD; k++) begin
      if (addr == code_addr(2'(k))) begin
        code_hit = 1'b1;
        code_sel = nv_cmd_e'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q    <= 1'b1;
      idx_q   <= '0;
      cmd_vld <= 1'b0;
      cmd     <= CMD_STORE;
    end else begin
      ce_q    <= ce_n;
      cmd_vld <= 1'b0;
      if (!en || wr_seen) begin
        idx_q <= '0;
      end else if (rd_start) begin
        if (idx_q == LAST && code_hit) begin
          cmd_vld <= 1'b1;
          cmd     <= code_sel;
          idx_q   <= '0;
        end else if (idx_q != LAST && pre_hit) begin
          idx_q <= idx_q + 1'b1;
        end else begin
          idx_q <= first_hit ? IDX_W'(1) : '0;
        end
      end
    end
  end

  // a command needs a fresh access start, so it never repeats back to back
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> !cmd_vld); // R1
endmodule

// File: rtl/nv_op_fsm.sv
module nv_op_fsm
  import nv_cmd_pkg::*;
#(
  parameter int unsigned STORE_CYC    = 40,
  parameter int unsigned RECALL_CYC   = 20,
  parameter int unsigned RESTORE_CYC  = 30,
  parameter int unsigned HW_DELAY_CYC = 10,
  parameter bit          INHIBIT_INIT = 1'b0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    power_good,
  input  logic    busy_line_n,
  input  logic    cmd_vld,
  input  nv_cmd_e cmd,
  input  logic    wr_done,
  output nv_st_e  st,
  output logic    busy_pull,
  output logic    arr_store,
  output logic    arr_clear,
  output logic    arr_load,
  output logic    auto_inhibit
);
  localparam int unsigned M1   = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int unsigned M2   = (RESTORE_CYC > HW_DELAY_CYC) ? RESTORE_CYC : HW_DELAY_CYC;
  localparam int unsigned MAXC = (M1 > M2) ? M1 : M2;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  nv_st_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dirty_q, inhibit_q, restore_q, dirty_nx;

  assign dirty_nx = dirty_q | wr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_PWROFF;
      cnt_q     <= '0;
      dirty_q   <= 1'b0;
      inhibit_q <= INHIBIT_INIT;
      restore_q <= 1'b1;
    end else begin
      if (wr_done) dirty_q <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (!power_good) begin
            if (dirty_q && !inhibit_q) begin
              st_q  <= ST_STORE;
              cnt_q <= CNT_W'(STORE_CYC - 1);
            end else begin
              st_q <= ST_PWROFF;
            end
          end else if (!busy_line_n) begin
            st_q  <= ST_HWDLY;
            cnt_q <= CNT_W'(HW_DELAY_CYC - 1);
          end else if (cmd_vld) begin
            case (cmd)
              CMD_STORE: begin
                st_q  <= ST_STORE;
                cnt_q <= CNT_W'(STORE_CYC - 1);
              end
              CMD_RECALL: begin
                st_q      <= ST_CLEAR;
                restore_q <= 1'b0;
              end
              CMD_INH_ON:  inhibit_q <= 1'b1;
              default:     inhibit_q <= 1'b0;
            endcase
          end
        end
        ST_HWDLY: begin
          if (cnt_q == '0) begin
            if (dirty_nx) begin
              st_q  <= ST_STORE;
              cnt_q <= CNT_W'(STORE_CYC - 1);
            end else begin
              st_q <= ST_WAITHI;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_STORE: begin
          if (cnt_q == '0) begin
            dirty_q <= 1'b0;
            st_q    <= power_good ? ST_WAITHI : ST_PWROFF;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WAITHI: begin
          if (!power_good)     st_q <= ST_PWROFF;
          else if (busy_line_n) st_q <= ST_IDLE;
        end
        ST_PWROFF: begin
          if (power_good) begin
            st_q      <= ST_CLEAR;
            restore_q <= 1'b1;
          end
        end
        ST_CLEAR: begin
          st_q  <= ST_LOAD;
          cnt_q <= restore_q ? CNT_W'(RESTORE_CYC - 1) : CNT_W'(RECALL_CYC - 1);
        end
        ST_LOAD: begin
          if (cnt_q == '0) begin
            dirty_q <= 1'b0;
            st_q    <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st           = st_q;
  assign busy_pull    = (st_q == ST_STORE);
  assign arr_store    = (st_q == ST_STORE);
  assign arr_clear    = (st_q == ST_CLEAR);
  assign arr_load     = (st_q == ST_LOAD);
  assign auto_inhibit = inhibit_q;

  AST_CLEAR_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_load) |-> $past(arr_clear)); // R7

  AST_PF_STORE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STORE && $past(st_q) == ST_IDLE && !$past(power_good))
      |-> $past(dirty_q && !inhibit_q)); // R9

  AST_INHIBIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !power_good |=> $stable(inhibit_q)); // R8
endmodule

// File: rtl/nv_cmd_ctrl.sv
module nv_cmd_ctrl
  import nv_cmd_pkg::*;
#(
  parameter int unsigned STORE_CYC    = 40,
  parameter int unsigned RECALL_CYC   = 20,
  parameter int unsigned RESTORE_CYC  = 30,
  parameter int unsigned HW_DELAY_CYC = 10,
  parameter bit          INHIBIT_INIT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMP_W-1:0] bus_addr,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             power_good,
  input  logic             busy_line_n,
  output logic             busy_pull,
  output logic             ram_en,
  output logic             ram_wr_en,
  output logic             dq_oe,
  output logic             arr_store,
  output logic             arr_clear,
  output logic             arr_load,
  output logic             auto_inhibit
);
  nv_st_e  st;
  logic    cmd_vld, wr_ok_q, acc_wr;
  nv_cmd_e cmd;

  nv_seq_detect u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (st == ST_IDLE),
    .addr    (bus_addr),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .cmd_vld (cmd_vld),
    .cmd     (cmd)
  );

  nv_op_fsm #(
    .STORE_CYC    (STORE_CYC),
    .RECALL_CYC   (RECALL_CYC),
    .RESTORE_CYC  (RESTORE_CYC),
    .HW_DELAY_CYC (HW_DELAY_CYC),
    .INHIBIT_INIT (INHIBIT_INIT)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .power_good   (power_good),
    .busy_line_n  (busy_line_n),
    .cmd_vld      (cmd_vld),
    .cmd          (cmd),
    .wr_done      (ram_wr_en),
    .st           (st),
    .busy_pull    (busy_pull),
    .arr_store    (arr_store),
    .arr_clear    (arr_clear),
    .arr_load     (arr_load),
    .auto_inhibit (auto_inhibit)
  );

  assign acc_wr    = !ce_n && !we_n;
  assign ram_en    = power_good && (st == ST_IDLE || st == ST_HWDLY);
  // a write survives a busy request only if it was already accepted
  assign ram_wr_en = ram_en && acc_wr && (busy_line_n || wr_ok_q);
  assign dq_oe     = ram_en && !ce_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ok_q <= 1'b0;
    else        wr_ok_q <= ram_wr_en;
  end

  AST_NO_NEW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr_en && !$past(ram_wr_en)) |-> busy_line_n); // R5

  AST_OP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_store || arr_clear || arr_load) |-> (!dq_oe && !ram_wr_en)); // R11

  AST_PWR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !power_good |-> !ram_wr_en); // R9
endmodule

// File: tb/nv_cmd_ctrl_tb.sv
module nv_cmd_ctrl_tb;
  localparam int STORE_CYC = 40, RECALL_CYC = 20, RESTORE_CYC = 30, HW_DELAY_CYC = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, power_good = 1'b1, ext_req = 1'b0;
  logic busy_line_n, busy_pull, ram_en, ram_wr_en, dq_oe;
  logic arr_store, arr_clear, arr_load, auto_inhibit;

  int n_store = 0, n_clear = 0, n_load = 0, n_pull = 0;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  int s_st, s_cl, s_ld, s_pl;

  always #5 clk = ~clk;
  assign busy_line_n = ~(busy_pull | ext_req);

  nv_cmd_ctrl #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC),
                .RESTORE_CYC(RESTORE_CYC), .HW_DELAY_CYC(HW_DELAY_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .power_good(power_good), .busy_line_n(busy_line_n),
    .busy_pull(busy_pull), .ram_en(ram_en), .ram_wr_en(ram_wr_en), .dq_oe(dq_oe),
    .arr_store(arr_store), .arr_clear(arr_clear), .arr_load(arr_load),
    .auto_inhibit(auto_inhibit));

  always @(negedge clk) begin
    if (arr_store) n_store++;
    if (arr_clear) n_clear++;
    if (arr_load)  n_load++;
    if (busy_pull) n_pull++;
  end

  function automatic logic [15:0] pre(int i);
    case (i)
      0: return 16'h4E38; 1: return 16'hB1C7; 2: return 16'h83E0;
      3: return 16'h7C1F; default: return 16'h703F;
    endcase
  endfunction
  localparam logic [15:0] C_ST = 16'h8FC0, C_RC = 16'h4C63, C_IN = 16'h8B45, C_IO = 16'h4B46;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic snap();
    s_st = n_store; s_cl = n_clear; s_ld = n_load; s_pl = n_pull;
  endtask

  task automatic rd(logic [15:0] a);
    tick(); bus_addr = a; ce_n = 1'b0; we_n = 1'b1;
    tick(); ce_n = 1'b1;
  endtask

  task automatic wr(logic [15:0] a);
    tick(); bus_addr = a; ce_n = 1'b0; we_n = 1'b0;
    tick(); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic unlock(logic [15:0] code);
    for (int i = 0; i < 5; i++) rd(pre(i));
    rd(code);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    // reset state
    chk("R10 reset ram_en", ram_en, 0);
    chk("R3 reset busy_pull", busy_pull, 0);
    chk("R8 reset auto_inhibit", auto_inhibit, 0);
    snap();
    rst_n = 1'b1;
    tick(RESTORE_CYC + 10);
    chk("R10 restore clear cycles", n_clear - s_cl, 1);
    chk("R10 restore load cycles", n_load - s_ld, RESTORE_CYC);
    chk("R10 ram_en after restore", ram_en, 1);

    // idle read drives bus
    tick(); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; bus_addr = 16'h1234; #1;
    chk("R11 dq_oe idle read", dq_oe, 1);
    tick(); ce_n = 1'b1; oe_n = 1'b1;

    // software store on a clean RAM
    snap();
    unlock(C_ST);
    tick(2);
    chk("R11 ram_en during store", ram_en, 0);
    chk("R3 busy line low during store", busy_line_n, 0);
    ce_n = 1'b0; oe_n = 1'b0; #1;
    chk("R11 dq_oe during store", dq_oe, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    tick(STORE_CYC + 10);
    chk("R3 store cycles", n_store - s_st, STORE_CYC);
    chk("R3 busy pull cycles", n_pull - s_pl, STORE_CYC);
    chk("R6 ram_en after store", ram_en, 1);

    // software recall with exact timing
    snap();
    unlock(C_RC);
    tick();
    chk("R7 clear first", arr_clear, 1);
    chk("R7 load not yet", arr_load, 0);
    tick();
    chk("R7 load follows", arr_load, 1);
    tick(RECALL_CYC + 5);
    chk("R7 recall load cycles", n_load - s_ld, RECALL_CYC);
    chk("R7 no store in recall", n_store - s_st, 0);

    // aborted sequences: wrong address or write at each position
    for (int pos = 0; pos < 6; pos++) begin
      for (int v = 0; v < 2; v++) begin
        snap();
        for (int i = 0; i < 6; i++) begin
          logic [15:0] a;
          a = (i < 5) ? pre(i) : C_ST;
          if (i == pos && v == 0) rd(a ^ 16'h0001);
          else if (i == pos)      wr(a);
          else                    rd(a);
        end
        tick(5);
        chk($sformatf("R2 abort pos %0d kind %0d", pos, v), n_store - s_st, 0);
        if (v == 1) begin
          // the write made the RAM dirty; a recall cleans it again
          unlock(C_RC);
          tick(RECALL_CYC + 5);
        end
      end
    end

    // inhibit on; power fail with dirty RAM stores nothing
    unlock(C_IN);
    tick(2);
    chk("R8 inhibit set", auto_inhibit, 1);
    wr(16'h0042);
    snap();
    power_good = 1'b0;
    tick(10);
    chk("R8 no store while inhibited", n_store - s_st, 0);
    chk("R9 ram_en power down", ram_en, 0);
    ce_n = 1'b0; we_n = 1'b0; #1;
    chk("R9 write ignored power down", ram_wr_en, 0);
    tick(); ce_n = 1'b1; we_n = 1'b1;
    ext_req = 1'b1;
    tick(5);
    chk("R9 busy request ignored power down", n_pull - s_pl, 0);
    ext_req = 1'b0;
    tick();
    power_good = 1'b1;
    tick(RESTORE_CYC + 10);
    chk("R10 restore on power return", n_load - s_ld, RESTORE_CYC);
    chk("R8 inhibit survives power cycle", auto_inhibit, 1);

    // inhibit off; power fail store on dirty RAM
    unlock(C_IO);
    tick(2);
    chk("R8 inhibit cleared", auto_inhibit, 0);
    wr(16'h0043);
    snap();
    power_good = 1'b0;
    tick(STORE_CYC + 10);
    chk("R9 power fail store", n_store - s_st, STORE_CYC);
    power_good = 1'b1;
    tick(RESTORE_CYC + 10);
    chk("R10 ram_en after second restore", ram_en, 1);

    // hardware request on clean RAM: window then no store
    snap();
    ext_req = 1'b1;
    tick(3);
    chk("R4 ram_en in delay window", ram_en, 1);
    tick(HW_DELAY_CYC + 10);
    chk("R4 clean hardware store skipped", n_store - s_st, 0);
    chk("R6 held disabled while line low", ram_en, 0);
    ext_req = 1'b0;
    tick(2);
    chk("R6 enabled after line high", ram_en, 1);

    // in-flight write survives, new write blocked, dirty store runs
    snap();
    ce_n = 1'b0; we_n = 1'b0; bus_addr = 16'h0100;
    tick();
    ext_req = 1'b1; #1;
    chk("R5 in-flight write kept same cycle", ram_wr_en, 1);
    tick();
    chk("R5 in-flight write kept in window", ram_wr_en, 1);
    ce_n = 1'b1; we_n = 1'b1;
    tick();
    ce_n = 1'b0; we_n = 1'b0; #1;
    chk("R5 new write blocked", ram_wr_en, 0);
    tick(); ce_n = 1'b1; we_n = 1'b1;
    tick(HW_DELAY_CYC + STORE_CYC + 10);
    chk("R4 dirty hardware store", n_store - s_st, STORE_CYC);
    chk("R6 disabled after store while line low", ram_en, 0);
    ext_req = 1'b0;
    tick(2);
    chk("R6 enabled after release", ram_en, 1);

    // sixth read and busy request in the same cycle
    snap();
    for (int i = 0; i < 5; i++) rd(pre(i));
    tick(); bus_addr = C_ST; ce_n = 1'b0; we_n = 1'b1; ext_req = 1'b1;
    tick(); ce_n = 1'b1;
    tick(HW_DELAY_CYC + 10);
    chk("R12 command discarded no store", n_store - s_st, 0);
    chk("R12 command discarded no clear", n_clear - s_cl, 0);
    chk("R12 waiting for line", ram_en, 0);
    ext_req = 1'b0;
    tick(2);
    unlock(C_RC);
    tick(RECALL_CYC + 5);
    chk("R11 detector fresh after op", n_clear - s_cl, 1);

    // commands issued during an operation are ignored
    snap();
    unlock(C_ST);
    unlock(C_RC);
    tick(STORE_CYC + 10);
    chk("R11 recall ignored during store", n_clear - s_cl, 0);
    chk("R1 store ran once", n_store - s_st, STORE_CYC);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule